// File: doc/BRIEF.md
# Stalled Rotor Protection Timer

This block watches one Hall sensor line for signs of rotation and throttles the motor drive when the rotor is held still. A digital ramp counter replaces an external timing capacitor. The counter climbs quickly from a low code to a high code while drive is allowed. It then sinks slowly back to the low code while drive is withheld, and the cycle repeats. The result is a short burst of drive followed by a long pause. That pause is roughly eighteen times longer than the burst with the default settings.

Each rising edge of the Hall line marks one electrical period. Each such edge snaps the ramp back to its low code in the rising phase. While the motor turns, the ramp therefore never reaches the high code and drive stays permitted. A status flag reports rotation. It drops when the ramp first reaches the high code and returns on the next Hall edge. A disable input holds the block in its inactive state, with drive permitted and status on, for systems that do not use lock protection. Ramp steps come from a carrier tick input, and a prescaler slows the falling slope.

Top module: `stall_guard`

## Requirements
- R1: After reset the ramp sits at LO_CODE in the rising phase, with drive_ok_o=1 and spinning_o=1.
- R2: In the rising phase each tick_i adds RISE_STEP. The tick that brings the ramp to HI_CODE or above clamps it at HI_CODE and switches to the falling phase. From the next cycle drive_ok_o=0 and spinning_o=0. With defaults the 32nd tick after LO does this.
- R3: In the falling phase the ramp drops FALL_STEP once every FALL_DIV ticks, and drive_ok_o stays 0. With defaults the falling phase lasts exactly 576 ticks.
- R4: When the falling ramp reaches LO_CODE, the rising phase resumes and drive_ok_o returns to 1. spinning_o stays 0 until a Hall edge.
- R5: A rising edge on hall_a_i (0 in one sampled cycle, 1 in the next) reloads the ramp to LO_CODE in the rising phase and sets spinning_o=1 from the next cycle. A falling edge on hall_a_i changes nothing.
- R6: When a Hall rising edge and the tick that would reach HI_CODE arrive in the same cycle, the Hall reload wins. The ramp restarts at LO_CODE and drive stays on.
- R7: While prot_dis_i=1, drive_ok_o=1 and spinning_o=1 whatever the ticks, and the ramp is held at LO_CODE. After release, a full rise from LO_CODE is needed before drive stops.
- R8: The ramp code never leaves the range LO_CODE to HI_CODE, and it changes only on a tick, a Hall reload or disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Carrier tick, one-cycle strobe that advances the ramp |
| hall_a_i | input | 1 | Digital level of one Hall sensor phase |
| prot_dis_i | input | 1 | 1 keeps protection inactive |
| drive_ok_o | output | 1 | 1 permits drive to the commutation logic |
| spinning_o | output | 1 | 1 while rotation is assumed, 0 after a lock is detected |

## Verification
The Hall reload and the threshold crossing can fall in the same clock edge, and only one of them may decide the next phase. The bench brings the ramp to one step below the high code. It then raises the Hall line on the same edge as the tick that would reach the top. The outcome is judged at the ports. Drive and status must stay on, and then exactly 31 more ticks must pass with drive held before the 32nd tick stops it. That count shows the ramp restarted from the low code.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;
   typedef enum logic {
      PH_RISE = 1'b0,
      PH_FALL = 1'b1
   } ramp_phase_t;
endpackage

// File: rtl/sg_hall_edge.sv
module sg_hall_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic hall_i,
   output logic pulse_o
);
   logic hall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hall_q <= 1'b0;
      else        hall_q <= hall_i;
   end

   assign pulse_o = hall_i & ~hall_q;
endmodule

// File: rtl/sg_prescaler.sv
module sg_prescaler #(
   parameter int DIV = 18
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic tick_i,
   output logic strobe_o
);
   generate
      if (DIV == 1) begin : g_pass
         assign strobe_o = tick_i & ~clr_i;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            pre <= '0;
            else if (clr_i)        pre <= '0;
            else if (tick_i) begin
               if (pre == LAST)    pre <= '0;
               else                pre <= pre + 1'b1;
            end
         end

         assign strobe_o = tick_i & ~clr_i & (pre == LAST);
      end
   endgenerate
endmodule

// File: rtl/sg_ramp.sv
module sg_ramp
   import stall_guard_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int LO_CODE   = 16,
   parameter int HI_CODE   = 48,
   parameter int RISE_STEP = 1,
   parameter int FALL_STEP = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dis_i,
   input  logic             reload_i,
   input  logic             up_i,
   input  logic             down_i,
   output logic [CNT_W-1:0] cnt_o,
   output ramp_phase_t      phase_o,
   output logic             spin_o
);
   localparam int SW = CNT_W + 1;
   localparam logic [SW-1:0] LO_W = SW'(LO_CODE);
   localparam logic [SW-1:0] HI_W = SW'(HI_CODE);
   localparam logic [SW-1:0] RS_W = SW'(RISE_STEP);
   localparam logic [SW-1:0] FS_W = SW'(FALL_STEP);
   localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO_CODE);
   localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI_CODE);

   logic [SW-1:0] cnt_w;
   assign cnt_w = {1'b0, cnt_o};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o   <= LO_C;
         phase_o <= PH_RISE;
         spin_o  <= 1'b1;
      end else if (dis_i || reload_i) begin
         cnt_o   <= LO_C;
         phase_o <= PH_RISE;
         spin_o  <= 1'b1;
      end else if (phase_o == PH_RISE) begin
         if (up_i) begin
            if (cnt_w + RS_W >= HI_W) begin
               cnt_o   <= HI_C;
               phase_o <= PH_FALL;
               spin_o  <= 1'b0;
            end else begin
               cnt_o <= cnt_o + CNT_W'(RISE_STEP);
            end
         end
      end else if (down_i) begin
         if (cnt_w <= LO_W + FS_W) begin
            cnt_o   <= LO_C;
            phase_o <= PH_RISE;
         end else begin
            cnt_o <= cnt_o - CNT_W'(FALL_STEP);
         end
      end
   end
endmodule

// File: rtl/stall_guard.sv
module stall_guard
   import stall_guard_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int LO_CODE   = 16,
   parameter int HI_CODE   = 48,
   parameter int RISE_STEP = 1,
   parameter int FALL_STEP = 1,
   parameter int FALL_DIV  = 18
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic hall_a_i,
   input  logic prot_dis_i,
   output logic drive_ok_o,
   output logic spinning_o
);
   generate
      if (LO_CODE >= HI_CODE) begin : g_bad_range
         $error("stall_guard: LO_CODE must be below HI_CODE");
      end
      if (HI_CODE >= (1 << CNT_W)) begin : g_bad_width
         $error("stall_guard: HI_CODE does not fit CNT_W");
      end
      if (RISE_STEP < 1 || FALL_STEP < 1 || FALL_DIV < 1) begin : g_bad_step
         $error("stall_guard: steps and divider must be positive");
      end
   endgenerate

   logic             hall_pulse;
   logic             fall_strobe;
   logic             in_fall;
   logic [CNT_W-1:0] cnt;
   ramp_phase_t      phase;

   sg_hall_edge i_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .hall_i  (hall_a_i),
      .pulse_o (hall_pulse)
   );

   sg_prescaler #(.DIV(FALL_DIV)) i_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (~in_fall | prot_dis_i | hall_pulse),
      .tick_i   (tick_i),
      .strobe_o (fall_strobe)
   );

   sg_ramp #(
      .CNT_W     (CNT_W),
      .LO_CODE   (LO_CODE),
      .HI_CODE   (HI_CODE),
      .RISE_STEP (RISE_STEP),
      .FALL_STEP (FALL_STEP)
   ) i_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .dis_i    (prot_dis_i),
      .reload_i (hall_pulse),
      .up_i     (tick_i),
      .down_i   (fall_strobe),
      .cnt_o    (cnt),
      .phase_o  (phase),
      .spin_o   (spinning_o)
   );

   assign in_fall    = (phase == PH_FALL);
   assign drive_ok_o = prot_dis_i | ~in_fall;
endmodule

// File: rtl/stall_guard_chk.sv
module stall_guard_chk #(
   parameter int CNT_W   = 8,
   parameter int LO_CODE = 16,
   parameter int HI_CODE = 48
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             prot_dis_i,
   input logic             drive_ok_o,
   input logic             spinning_o,
   input logic             hall_pulse,
   input logic             in_fall,
   input logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO_CODE);
   localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI_CODE);

   p_bounds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt >= LO_C) && (cnt <= HI_C));

   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !hall_pulse && !prot_dis_i) |=> $stable(cnt));

   p_hall_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hall_pulse && !prot_dis_i) |=> (cnt == LO_C) && spinning_o && drive_ok_o);

   p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      prot_dis_i |=> drive_ok_o && spinning_o && (cnt == LO_C));

   p_lock_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spinning_o) |-> in_fall && (cnt == HI_C));

   p_fall_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_fall) |-> (cnt == HI_C) && !drive_ok_o);

   p_rise_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_fall) |-> (cnt == LO_C));
endmodule

bind stall_guard stall_guard_chk #(
   .CNT_W   (CNT_W),
   .LO_CODE (LO_CODE),
   .HI_CODE (HI_CODE)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_i     (tick_i),
   .prot_dis_i (prot_dis_i),
   .drive_ok_o (drive_ok_o),
   .spinning_o (spinning_o),
   .hall_pulse (hall_pulse),
   .in_fall    (in_fall),
   .cnt        (cnt)
);

// File: tb/test_stall_guard.sv
`timescale 1ns/1ps
module test_stall_guard;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_i = 1'b0;
   logic hall_a_i = 1'b0;
   logic prot_dis_i = 1'b0;
   logic drive_ok_o;
   logic spinning_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   stall_guard i_stall_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .hall_a_i   (hall_a_i),
      .prot_dis_i (prot_dis_i),
      .drive_ok_o (drive_ok_o),
      .spinning_o (spinning_o)
   );

   // ticks to apply, then expected drive and status (defaults: 32 up, 576 down)
   localparam int NV = 6;
   localparam int  V_TICKS[NV] = '{31, 1, 575, 1, 31, 1};
   localparam bit  V_DRV[NV]   = '{1,  0, 0,   1, 1,  0};
   localparam bit  V_SPN[NV]   = '{1,  0, 0,   0, 0,  0};
   localparam string V_TAG[NV] = '{"R2", "R2", "R3", "R4", "R4", "R4"};

   task automatic check(input string tag, input bit exp_d, input bit exp_s);
      checks++;
      if (drive_ok_o !== exp_d || spinning_o !== exp_s) begin
         failures++;
         $display("FAIL %s: actual drive=%b spin=%b expected drive=%b spin=%b",
                  tag, drive_ok_o, spinning_o, exp_d, exp_s);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_i = 1'b1;
         @(negedge clk) tick_i = 1'b0;
      end
   endtask

   task automatic hall_rise();
      @(negedge clk) hall_a_i = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R1: watchdog actual=timeout expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", 1'b1, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 1'b1, 1'b1);

      for (int v = 0; v < NV; v++) begin
         ticks(V_TICKS[v]);
         check(V_TAG[v], V_DRV[v], V_SPN[v]);
      end

      // R5: rising Hall edge during the falling phase reloads the ramp
      ticks(40);
      check("R3", 1'b0, 1'b0);
      hall_rise();
      check("R5", 1'b1, 1'b1);
      ticks(31);
      check("R5", 1'b1, 1'b1);
      ticks(1);
      check("R5", 1'b0, 1'b0);

      // R5: falling Hall edge has no effect
      @(negedge clk) hall_a_i = 1'b0;
      repeat (3) @(negedge clk);
      check("R5", 1'b0, 1'b0);

      // R6: Hall edge and the topping tick on the same edge
      hall_rise();
      @(negedge clk) hall_a_i = 1'b0;
      ticks(31);
      check("R6", 1'b1, 1'b1);
      @(negedge clk) begin hall_a_i = 1'b1; tick_i = 1'b1; end
      @(negedge clk) tick_i = 1'b0;
      check("R6", 1'b1, 1'b1);
      ticks(31);
      check("R6", 1'b1, 1'b1);
      ticks(1);
      check("R6", 1'b0, 1'b0);

      // R7: disable holds protection inactive
      @(negedge clk) prot_dis_i = 1'b1;
      @(negedge clk);
      check("R7", 1'b1, 1'b1);
      ticks(100);
      check("R7", 1'b1, 1'b1);
      @(negedge clk) prot_dis_i = 1'b0;
      ticks(31);
      check("R7", 1'b1, 1'b1);
      ticks(1);
      check("R7", 1'b0, 1'b0);

      // R1: reset mid-lock returns to the initial state
      ticks(5);
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk);
      check("R1", 1'b1, 1'b1);
      rst_n = 1'b1;
      ticks(31);
      check("R1", 1'b1, 1'b1);
      ticks(1);
      check("R2", 1'b0, 1'b0);

      done = 1'b1;
      finish_run();
   end
endmodule